// File: doc/BRIEF.md
# Serial Management Slave with Register Bank

This block is the management-port end of a PHY. It is clocked by the management clock and watches a shared, bidirectional data line. It finds a frame by counting a run of logic-one bits. It then collects a start pattern, an operation code, a device address and a register index. When the device address matches the value on its strap pins, it either drives a register's contents back onto the line or stores a 16-bit value that the master shifts in.

The register space has 32 slots. Only the low standard group (indices 0 to 6) and the high vendor group (indices 16 to 31) hold storage. The gap in between reads as zero. The rest of the PHY sees every register at once through a flat bus, and it can load any implemented register through a local write port. The line driver itself sits outside the block: the block supplies an output-enable and an output value, and takes the resolved line level as input.

Top module: `mdio_reg_slave`

## Requirements
- R1: After reset, `mdio_oe` is low and every register reads zero.
- R2: A frame is accepted only after at least 32 consecutive ones sampled on the line. A shorter run followed by a frame has no effect.
- R3: The start pattern must be the bit 0 followed by the bit 1. Any other pair aborts the frame, and the slave then waits for a fresh 32-one run.
- R4: After the start pattern, the operation code 01 selects a write and 10 selects a read. The codes 00 and 11 are ignored. Next come a 5-bit device address and then a 5-bit register index, both most significant bit first, followed by 2 turnaround bits and 16 data bits, also most significant bit first.
- R5: A frame whose device address differs from `phy_addr` changes no register and never raises `mdio_oe`.
- R6: On a write, the register keeps its old value until the 16th data bit has been sampled. It holds the new value from the following cycle.
- R7: On a read, `mdio_oe` rises in time for the second turnaround bit, which is driven as 0. It stays high through the last data bit, which makes exactly 17 bit times, and `mdio_o` carries the register most significant bit first.
- R8: Indices 0 to 6 and 16 to 31 store written values. Indices 7 to 15 always read 0, and writes to them are dropped.
- R9: A pulse on `loc_we` loads `loc_wdata` into the implemented register `loc_idx` at that edge. When a management write lands on the same register in the same cycle, the management value is kept.
- R10: On `reg_flat`, register i occupies bits [16*i+15 : 16*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the line is sampled and driven on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped device address compared with each frame |
| mdio_i | input | 1 | Resolved level of the shared data line |
| mdio_o | output | 1 | Value to drive onto the line while enabled |
| mdio_oe | output | 1 | Output enable for the line driver |
| loc_we | input | 1 | Local write strobe from the PHY core |
| loc_idx | input | 5 | Register index for the local write |
| loc_wdata | input | 16 | Data for the local write |
| reg_flat | output | 512 | All 32 registers side by side, register 0 in the low bits |

## Verification
The management write commit and the local write port can fire on the same edge and address the same register. The bench provokes this by raising `loc_we` with a different value exactly in the bit time of the 16th data bit of a management write. It judges the result by reading `reg_flat` one cycle later and expecting the management value. A second collision run targets two different registers, and there both values must land.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [1:0] {
      FR_HUNT,
      FR_HEAD,
      FR_TURN,
      FR_DATA
   } fr_state_t;

   localparam int HEAD_BITS = 13;

   function automatic logic slot_present(input int idx, input int std_last,
                                         input int vnd_first);
      return (idx <= std_last) || (idx >= vnd_first);
   endfunction

endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int DW      = 16,
   parameter int AW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] phy_addr,
   input  logic          mdio_i,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          mdio_o,
   output logic          mdio_oe
);

   localparam int PCW = $clog2(PRE_LEN + 1);
   localparam int BCW = $clog2(DW + HEAD_BITS);

   if (AW != 5) begin : g_bad_aw
      $error("frame layout needs a 5-bit address");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("preamble length must be positive");
   end
   if (DW < 2) begin : g_bad_dw
      $error("data width too small");
   end

   fr_state_t              st;
   logic [PCW-1:0]         pre_cnt;
   logic [BCW-1:0]         bcnt;
   logic [HEAD_BITS-2:0]   head;
   logic [HEAD_BITS-1:0]   head_all;
   logic                   is_rd;
   logic [AW-1:0]          reg_q;
   logic [DW-1:0]          sh;
   logic                   head_last;
   logic                   head_ok;
   logic                   data_last;

   assign head_all  = {head, mdio_i};
   assign head_last = (st == FR_HEAD) && (bcnt == BCW'(HEAD_BITS - 1));
   assign head_ok   = head_all[12]
                    && (head_all[11:10] == 2'b01 || head_all[11:10] == 2'b10)
                    && (head_all[9:5] == phy_addr);
   assign data_last = (st == FR_DATA) && (bcnt == BCW'(DW - 1));

   assign rd_addr = reg_q;
   assign wr_addr = reg_q;
   assign wr_en   = data_last && !is_rd;
   assign wr_data = {sh[DW-2:0], mdio_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FR_HUNT;
         pre_cnt <= '0;
         bcnt    <= '0;
         head    <= '0;
         is_rd   <= 1'b0;
         reg_q   <= '0;
         sh      <= '0;
         mdio_oe <= 1'b0;
         mdio_o  <= 1'b0;
      end else begin
         case (st)
            FR_HUNT: begin
               if (mdio_i) begin
                  if (pre_cnt != PCW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
               end else if (pre_cnt == PCW'(PRE_LEN)) begin
                  st      <= FR_HEAD;
                  bcnt    <= '0;
                  pre_cnt <= '0;
               end else begin
                  pre_cnt <= '0;
               end
            end
            FR_HEAD: begin
               head <= head_all[HEAD_BITS-2:0];
               bcnt <= bcnt + 1'b1;
               if (head_last) begin
                  bcnt <= '0;
                  if (head_ok) begin
                     st    <= FR_TURN;
                     is_rd <= (head_all[11:10] == 2'b10);
                     reg_q <= head_all[4:0];
                  end else begin
                     st    <= FR_HUNT;
                  end
               end
            end
            FR_TURN: begin
               bcnt <= bcnt + 1'b1;
               if (bcnt == '0) begin
                  if (is_rd) begin
                     mdio_oe <= 1'b1;
                     mdio_o  <= 1'b0;
                     sh      <= rd_data;
                  end
               end else begin
                  if (is_rd) begin
                     mdio_o <= sh[DW-1];
                     sh     <= {sh[DW-2:0], 1'b0};
                  end
                  st   <= FR_DATA;
                  bcnt <= '0;
               end
            end
            FR_DATA: begin
               sh   <= {sh[DW-2:0], mdio_i};
               bcnt <= bcnt + 1'b1;
               if (is_rd) mdio_o <= sh[DW-1];
               if (data_last) begin
                  mdio_oe <= 1'b0;
                  mdio_o  <= 1'b0;
                  st      <= FR_HUNT;
                  bcnt    <= '0;
               end
            end
            default: st <= FR_HUNT;
         endcase
      end
   end

   logic [BCW:0] oe_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_run <= '0;
      else        oe_run <= mdio_oe ? oe_run + 1'b1 : '0;
   end

   // R7
   ta_drive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   // R7
   oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> is_rd && (st == FR_TURN || st == FR_DATA));

   // R7
   oe_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdio_oe) |-> oe_run == (BCW+1)'(DW + 1));

   // R6
   commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> st == FR_HUNT && !mdio_oe);

   // R5
   reject_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (head_last && !head_ok) |=> st == FR_HUNT && !mdio_oe);

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
   import mdio_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 5,
   parameter int STD_LAST  = 6,
   parameter int VND_FIRST = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   m_we,
   input  logic [AW-1:0]          m_addr,
   input  logic [DW-1:0]          m_wdata,
   input  logic                   l_we,
   input  logic [AW-1:0]          l_addr,
   input  logic [DW-1:0]          l_wdata,
   input  logic [AW-1:0]          rd_addr,
   output logic [DW-1:0]          rd_data,
   output logic [(1<<AW)*DW-1:0]  flat
);

   localparam int NREG = 1 << AW;

   if (STD_LAST >= VND_FIRST) begin : g_bad_split
      $error("standard group must end below vendor group");
   end
   if (VND_FIRST > NREG) begin : g_bad_vnd
      $error("vendor group starts beyond the address space");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      if (slot_present(i, STD_LAST, VND_FIRST)) begin : g_impl
         logic [DW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (m_we && m_addr == AW'(i))         q <= m_wdata;
            else if (l_we && l_addr == AW'(i))         q <= l_wdata;
         end
         assign flat[i*DW +: DW] = q;
      end else begin : g_hole
         assign flat[i*DW +: DW] = '0;
      end
   end

   assign rd_data = flat[rd_addr*DW +: DW];

   logic          chk_v;
   logic [AW-1:0] chk_a;
   logic [DW-1:0] chk_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_v <= 1'b0;
         chk_a <= '0;
         chk_d <= '0;
      end else begin
         chk_v <= m_we;
         chk_a <= m_addr;
         chk_d <= slot_present(int'(m_addr), STD_LAST, VND_FIRST) ? m_wdata : '0;
      end
   end

   // R8 R9
   mgmt_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_v |-> flat[chk_a*DW +: DW] == chk_d);

endmodule

// File: rtl/mdio_reg_slave.sv
module mdio_reg_slave #(
   parameter int PRE_LEN   = 32,
   parameter int DW        = 16,
   parameter int AW        = 5,
   parameter int STD_LAST  = 6,
   parameter int VND_FIRST = 16
) (
   input  logic                   mdc,
   input  logic                   rst_n,
   input  logic [AW-1:0]          phy_addr,
   input  logic                   mdio_i,
   output logic                   mdio_o,
   output logic                   mdio_oe,
   input  logic                   loc_we,
   input  logic [AW-1:0]          loc_idx,
   input  logic [DW-1:0]          loc_wdata,
   output logic [(1<<AW)*DW-1:0]  reg_flat
);

   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   mdio_frame_rx #(.PRE_LEN(PRE_LEN), .DW(DW), .AW(AW)) i_rx (
      .clk      (mdc),
      .rst_n    (rst_n),
      .phy_addr (phy_addr),
      .mdio_i   (mdio_i),
      .rd_data  (rd_data),
      .rd_addr  (rd_addr),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

   mdio_reg_bank #(.DW(DW), .AW(AW), .STD_LAST(STD_LAST), .VND_FIRST(VND_FIRST)) i_bank (
      .clk     (mdc),
      .rst_n   (rst_n),
      .m_we    (wr_en),
      .m_addr  (wr_addr),
      .m_wdata (wr_data),
      .l_we    (loc_we),
      .l_addr  (loc_idx),
      .l_wdata (loc_wdata),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .flat    (reg_flat)
   );

endmodule

// File: tb/test_mdio_reg_slave.sv
module test_mdio_reg_slave;

   localparam logic [4:0] MY_PHY = 5'h0B;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         m_drv = 1'b1;
   logic         m_bit = 1'b1;
   logic         line;
   logic         mdio_o, mdio_oe;
   logic         loc_we = 1'b0;
   logic [4:0]   loc_idx = '0;
   logic [15:0]  loc_wdata = '0;
   logic [511:0] reg_flat;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   assign line = mdio_oe ? mdio_o : (m_drv ? m_bit : 1'b1);

   mdio_reg_slave i_mdio_reg_slave (
      .mdc       (clk),
      .rst_n     (rst_n),
      .phy_addr  (MY_PHY),
      .mdio_i    (line),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .loc_we    (loc_we),
      .loc_idx   (loc_idx),
      .loc_wdata (loc_wdata),
      .reg_flat  (reg_flat)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] slot(input int a);
      return reg_flat[a*16 +: 16];
   endfunction

   function automatic logic [63:0] mk(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] phy, input logic [4:0] ra,
                                      input logic [15:0] d);
      return {32'hFFFF_FFFF, st, op, phy, ra, 2'b10, d};
   endfunction

   // Plays one 64-bit frame. With rd set the master releases the line from
   // the first turnaround bit. With pre_chk set, the target slot is compared
   // with pre_val just before the last data bit is sampled (R6).
   task automatic xfer(input logic [63:0] f, input bit rd, input bit col,
                       input logic [4:0] c_idx, input logic [15:0] c_dat,
                       input bit pre_chk, input int pre_slot, input logic [15:0] pre_val,
                       output logic [15:0] got, output int oe_n, output bit ta_ok);
      got = '0; oe_n = 0; ta_ok = 1'b0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (mdio_oe) oe_n++;
         if (i == 47) ta_ok = mdio_oe && !mdio_o;
         if (i >= 48) got[63-i] = mdio_o;
         m_drv = !(rd && i >= 46);
         m_bit = f[63-i];
         if (i == 63) begin
            if (pre_chk)
               chk(slot(pre_slot) == pre_val, "R6 value held before last bit",
                   32'(slot(pre_slot)), 32'(pre_val));
            if (col) begin
               loc_we = 1'b1; loc_idx = c_idx; loc_wdata = c_dat;
            end
         end
      end
      @(negedge clk);
      if (mdio_oe) oe_n++;
      loc_we = 1'b0;
      m_drv = 1'b1;
      m_bit = 1'b1;
   endtask

   task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
      logic [15:0] g; int n; bit t;
      xfer(mk(2'b01, 2'b01, phy, ra, d), 1'b0, 1'b0, '0, '0, 1'b0, 0, '0, g, n, t);
   endtask

   task automatic rd_chk(input logic [4:0] ra, input logic [15:0] exp, input string req);
      logic [15:0] g; int n; bit t;
      xfer(mk(2'b01, 2'b10, MY_PHY, ra, 16'h0), 1'b1, 1'b0, '0, '0, 1'b0, 0, '0, g, n, t);
      chk(g == exp, req, 32'(g), 32'(exp));
      chk(n == 17, "R7 enable length", n, 17);
      chk(t, "R7 second turnaround bit driven 0", 32'(t), 1);
   endtask

   task automatic t_reset();
      chk(!mdio_oe, "R1 enable low after reset", 32'(mdio_oe), 0);
      chk(reg_flat == '0, "R1 registers zero after reset", 32'(reg_flat[31:0]), 0);
   endtask

   task automatic t_std_write_read();
      logic [15:0] g; int n; bit t;
      xfer(mk(2'b01, 2'b01, MY_PHY, 5'd3, 16'hA5C3), 1'b0, 1'b0, '0, '0,
           1'b1, 3, 16'h0000, g, n, t);
      chk(slot(3) == 16'hA5C3, "R4 R10 write lands at slot 3", 32'(slot(3)), 32'hA5C3);
      chk(n == 0, "R7 no enable on write", n, 0);
      rd_chk(5'd3, 16'hA5C3, "R7 read back slot 3");
   endtask

   task automatic t_vendor();
      wr(MY_PHY, 5'd31, 16'h1234);
      wr(MY_PHY, 5'd16, 16'hBEEF);
      chk(slot(31) == 16'h1234, "R8 R10 slot 31 stored", 32'(slot(31)), 32'h1234);
      chk(slot(16) == 16'hBEEF, "R8 slot 16 stored", 32'(slot(16)), 32'hBEEF);
      rd_chk(5'd31, 16'h1234, "R8 read slot 31");
      rd_chk(5'd6, 16'h0000, "R8 read slot 6");
   endtask

   task automatic t_hole();
      wr(MY_PHY, 5'd9, 16'hFFFF);
      chk(slot(9) == 16'h0, "R8 gap slot 9 write dropped", 32'(slot(9)), 0);
      rd_chk(5'd9, 16'h0000, "R8 gap slot 9 reads zero");
   endtask

   task automatic t_phy();
      logic [15:0] g; int n; bit t;
      wr(5'h0A, 5'd4, 16'h7777);
      chk(slot(4) == 16'h0, "R5 foreign address write ignored", 32'(slot(4)), 0);
      xfer(mk(2'b01, 2'b10, 5'h1B, 5'd3, 16'h0), 1'b1, 1'b0, '0, '0, 1'b0, 0, '0, g, n, t);
      chk(n == 0, "R5 foreign address read keeps line released", n, 0);
   endtask

   task automatic t_start();
      wr(MY_PHY, 5'd5, 16'h0001);
      chk(slot(5) == 16'h0001, "R3 good start accepted", 32'(slot(5)), 1);
      begin
         logic [15:0] g; int n; bit t;
         xfer(mk(2'b00, 2'b01, MY_PHY, 5'd5, 16'h4242), 1'b0, 1'b0, '0, '0, 1'b0, 0, '0, g, n, t);
      end
      chk(slot(5) == 16'h0001, "R3 bad start pattern ignored", 32'(slot(5)), 1);
      wr(MY_PHY, 5'd5, 16'h0002);
      chk(slot(5) == 16'h0002, "R3 recovery after fresh preamble", 32'(slot(5)), 2);
   endtask

   task automatic t_short_pre();
      logic [63:0] f; logic [15:0] g; int n; bit t;
      f = mk(2'b01, 2'b01, MY_PHY, 5'd6, 16'h6666);
      f[63] = 1'b0;
      xfer(f, 1'b0, 1'b0, '0, '0, 1'b0, 0, '0, g, n, t);
      chk(slot(6) == 16'h0, "R2 31-one preamble rejected", 32'(slot(6)), 0);
   endtask

   task automatic t_opcode();
      logic [15:0] g; int n; bit t;
      xfer(mk(2'b01, 2'b11, MY_PHY, 5'd2, 16'h3333), 1'b0, 1'b0, '0, '0, 1'b0, 0, '0, g, n, t);
      chk(slot(2) == 16'h0, "R4 opcode 11 ignored", 32'(slot(2)), 0);
      xfer(mk(2'b01, 2'b00, MY_PHY, 5'd2, 16'h3333), 1'b1, 1'b0, '0, '0, 1'b0, 0, '0, g, n, t);
      chk(slot(2) == 16'h0, "R4 opcode 00 ignored", 32'(slot(2)), 0);
      chk(n == 0, "R4 opcode 00 no drive", n, 0);
   endtask

   task automatic t_local();
      @(negedge clk);
      loc_we = 1'b1; loc_idx = 5'd1; loc_wdata = 16'h0F0F;
      @(negedge clk);
      loc_idx = 5'd10; loc_wdata = 16'hDEAD;
      @(negedge clk);
      loc_we = 1'b0;
      chk(slot(1) == 16'h0F0F, "R9 local write slot 1", 32'(slot(1)), 32'h0F0F);
      chk(slot(10) == 16'h0, "R9 R8 local write to gap dropped", 32'(slot(10)), 0);
   endtask

   task automatic t_collide();
      logic [15:0] g; int n; bit t;
      xfer(mk(2'b01, 2'b01, MY_PHY, 5'd2, 16'h5555), 1'b0, 1'b1, 5'd2, 16'hAAAA,
           1'b0, 0, '0, g, n, t);
      chk(slot(2) == 16'h5555, "R9 management wins same-slot collision",
          32'(slot(2)), 32'h5555);
      xfer(mk(2'b01, 2'b01, MY_PHY, 5'd20, 16'h2020), 1'b0, 1'b1, 5'd0, 16'h0C0C,
           1'b0, 0, '0, g, n, t);
      chk(slot(20) == 16'h2020, "R9 management lands beside local", 32'(slot(20)), 32'h2020);
      chk(slot(0) == 16'h0C0C, "R9 local lands beside management", 32'(slot(0)), 32'h0C0C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_std_write_read();
      t_vendor();
      t_hole();
      t_phy();
      t_start();
      t_short_pre();
      t_opcode();
      t_local();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule